// File: doc/BRIEF.md
# Quad-View Camera Frame Compositor

This block gathers four camera pixel streams and turns them into one display frame for a four-sided display pyramid. Each camera runs on its own pixel clock and delivers 16-bit RGB565 words qualified by a line-valid strobe, plus a start-of-frame sync. Every camera fills a private dual-port frame bank of `IMG_W` x `IMG_H` pixels, stored in raster order. Production sizing is 320 x 240 per camera, which gives a 1280 x 720 frame at 60 Hz with a display clock near 75 MHz.

On the display side, the external timing generator supplies pixel coordinates, data-enable and the two sync signals. The compositor works out which bank, if any, covers each coordinate and reads the matching entry. It puts out the pixel one display clock later, with the sync and enable signals delayed to stay aligned. The frame is `4*IMG_W` wide and `3*IMG_H` tall. The four images form a cross, and everything else is black. A mirror mode takes camera 0 alone and writes its stream into all four banks, which is useful when only one camera is fitted.

Top module: `qv_quad_compositor`

## Requirements
- R1: Each camera lane captures `cam_data` on the rising edge of its own `cam_pclk` while its `cam_href` is high. It stores the words in raster order, so the n-th captured word of a frame lands at bank entry n.
- R2: While a lane's `cam_vs` is high, its write address returns to entry 0 and no word is stored. The next frame therefore starts again at entry 0.
- R3: A lane clock edge with `cam_href` low stores nothing and leaves the write address unchanged.
- R4: Words beyond the first `IMG_W*IMG_H` of a frame are discarded. No bank entry is overwritten by wrap-around.
- R5: Each frame band is `IMG_H` lines tall and each column is `IMG_W` pixels wide. Bank 0 sits at band 0, column 1. Bank 1 sits at band 1, column 0. Bank 2 sits at band 1, column 2. Bank 3 sits at band 2, column 1. A coordinate (x, y) inside a region shows bank entry `(y - top)*IMG_W + (x - left)`.
- R6: `pix_out` is 16'h0000 for every coordinate outside the four regions, including lines past the frame, and whenever `disp_de` is low.
- R7: `pix_out`, `out_de`, `out_hs` and `out_vs` reflect the display inputs sampled at the previous rising edge of `clk`. The latency is exactly one clock.
- R8: While `mirror_en` is high, camera 0's stream is written into all four banks, and the inputs of cameras 1 to 3 are ignored.
- R9: While `rst_n` is low, `pix_out`, `out_de`, `out_hs` and `out_vs` are 0.
- R10: The bank read address never reaches past entry `IMG_W*IMG_H-1` for any coordinate that selects a bank. As a result, no unwritten line shows up at the top or bottom of a region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| mirror_en | input | 1 | Route camera 0 into all four banks |
| cam_pclk | input | 4 | Per-camera pixel clocks, bit k for camera k |
| cam_vs | input | 4 | Per-camera start-of-frame sync, active high |
| cam_href | input | 4 | Per-camera line-valid strobe |
| cam_data | input | 64 | RGB565 words, camera k in bits 16k+15 to 16k |
| disp_x | input | $clog2(4*IMG_W) | Display column from the timing generator |
| disp_y | input | $clog2(3*IMG_H) | Display line from the timing generator |
| disp_de | input | 1 | Display data enable |
| disp_hs | input | 1 | Display horizontal sync |
| disp_vs | input | 1 | Display vertical sync |
| pix_out | output | 16 | Composed RGB565 pixel |
| out_de | output | 1 | Data enable delayed by one clock |
| out_hs | output | 1 | Horizontal sync delayed by one clock |
| out_vs | output | 1 | Vertical sync delayed by one clock |

## Verification
The first full-frame scan runs after all four cameras have written distinct value ranges at different clock rates. A bank swap, a shifted region corner or a wrong row stride then shows up as a wrong value at a known coordinate. A stream with idle gaps and an over-long stream separate correct address stepping from stepping on every edge, and from wrap-around into the first lines. A short frame followed by a full one shows whether the frame sync really restarts at entry 0. A mirror run, with another camera streaming at the same time, shows whether its data leaks into the banks. A scan with enable low, and a few lines past the frame, checks the black fill and the one-clock alignment of the syncs.

// File: rtl/qv_pkg.sv
`timescale 1ns/1ps
package qv_pkg;
    localparam int LANES = 4;
    localparam int PIX_W = 16;
    typedef logic [PIX_W-1:0] pix_t;
    localparam pix_t BLACK = '0;
endpackage

// File: rtl/qv_cam_writer.sv
`timescale 1ns/1ps
// Per-camera write address generator, lives in the camera clock domain.
module qv_cam_writer
    import qv_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int AW    = 6,
    parameter int CW    = 6
) (
    input  logic          pclk,
    input  logic          rst_n,
    input  logic          vs,
    input  logic          href,
    input  pix_t          din,
    output logic          we,
    output logic [AW-1:0] waddr,
    output pix_t          wdata,
    output logic [CW-1:0] addr_q
);
    typedef struct packed {
        logic [CW-1:0] addr;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        we   = 1'b0;
        if (vs) begin
            st_d.addr = '0;
        end else if (href && (st_q.addr < CW'(DEPTH))) begin
            we        = 1'b1;
            st_d.addr = st_q.addr + CW'(1);
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr  = st_q.addr[AW-1:0];
    assign wdata  = din;
    assign addr_q = st_q.addr;
endmodule

// File: rtl/qv_bank.sv
`timescale 1ns/1ps
// Simple dual-port frame bank: write in camera domain, registered read in display domain.
module qv_bank
    import qv_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int AW    = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  pix_t          wdata,
    input  logic          rclk,
    input  logic [AW-1:0] raddr,
    output pix_t          rdata
);
    pix_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/qv_region_map.sv
`timescale 1ns/1ps
// Maps a display coordinate onto one bank and an entry inside it.
module qv_region_map
    import qv_pkg::*;
#(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    parameter int XW    = 5,
    parameter int YW    = 5,
    parameter int AW    = 6
) (
    input  logic [XW-1:0]    x,
    input  logic [YW-1:0]    y,
    output logic [LANES-1:0] hit,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] off [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_reg
        // cross layout: column index and band index of each bank
        localparam int COL  = (g == 1) ? 0 : ((g == 2) ? 2 : 1);
        localparam int BAND = (g == 0) ? 0 : ((g == 3) ? 2 : 1);
        localparam int X0   = COL * IMG_W;
        localparam int Y0   = BAND * IMG_H;

        always_comb begin
            hit[g] = (int'(x) >= X0) && (int'(x) < X0 + IMG_W) &&
                     (int'(y) >= Y0) && (int'(y) < Y0 + IMG_H);
            off[g] = AW'((int'(y) - Y0) * IMG_W + (int'(x) - X0));
        end
    end

    always_comb begin
        addr = '0;
        for (int k = 0; k < LANES; k++) begin
            if (hit[k]) addr = off[k];
        end
    end
endmodule

// File: rtl/qv_quad_compositor.sv
`timescale 1ns/1ps
module qv_quad_compositor
    import qv_pkg::*;
#(
    parameter  int IMG_W = 8,
    parameter  int IMG_H = 6,
    localparam int XW    = $clog2(4 * IMG_W),
    localparam int YW    = $clog2(3 * IMG_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mirror_en,
    input  logic [3:0]    cam_pclk,
    input  logic [3:0]    cam_vs,
    input  logic [3:0]    cam_href,
    input  logic [63:0]   cam_data,
    input  logic [XW-1:0] disp_x,
    input  logic [YW-1:0] disp_y,
    input  logic          disp_de,
    input  logic          disp_hs,
    input  logic          disp_vs,
    output logic [15:0]   pix_out,
    output logic          out_de,
    output logic          out_hs,
    output logic          out_vs
);
    localparam int DEPTH = IMG_W * IMG_H;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    // ---------------- capture side ----------------
    logic [LANES-1:0]    lane_clk, lane_vs, lane_href;
    pix_t                lane_din [LANES];
    logic [LANES*CW-1:0] wa_flat;
    pix_t                bank_q   [LANES];

    logic [LANES-1:0] hit;
    logic [AW-1:0]    rd_addr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic          we;
        logic [AW-1:0] waddr;
        pix_t          wdata;
        logic [CW-1:0] addr_q;

        // mirror mode: lanes 1..3 follow camera 0 (change only while cameras idle)
        if (g == 0) begin : g_own
            assign lane_clk[g]  = cam_pclk[0];
            assign lane_vs[g]   = cam_vs[0];
            assign lane_href[g] = cam_href[0];
            assign lane_din[g]  = cam_data[PIX_W-1:0];
        end else begin : g_sel
            assign lane_clk[g]  = mirror_en ? cam_pclk[0] : cam_pclk[g];
            assign lane_vs[g]   = mirror_en ? cam_vs[0]   : cam_vs[g];
            assign lane_href[g] = mirror_en ? cam_href[0] : cam_href[g];
            assign lane_din[g]  = mirror_en ? cam_data[PIX_W-1:0]
                                            : cam_data[g*PIX_W +: PIX_W];
        end

        qv_cam_writer #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
            .pclk  (lane_clk[g]),
            .rst_n (rst_n),
            .vs    (lane_vs[g]),
            .href  (lane_href[g]),
            .din   (lane_din[g]),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .addr_q(addr_q)
        );

        assign wa_flat[g*CW +: CW] = addr_q;

        qv_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
            .wclk (lane_clk[g]),
            .we   (we),
            .waddr(waddr),
            .wdata(wdata),
            .rclk (clk),
            .raddr(rd_addr),
            .rdata(bank_q[g])
        );
    end

    // ---------------- display side ----------------
    qv_region_map #(.IMG_W(IMG_W), .IMG_H(IMG_H), .XW(XW), .YW(YW), .AW(AW)) u_map (
        .x   (disp_x),
        .y   (disp_y),
        .hit (hit),
        .addr(rd_addr)
    );

    typedef struct packed {
        logic [LANES-1:0] sel;
        logic             de;
        logic             hs;
        logic             vs;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.sel = disp_de ? hit : '0;
        pipe_d.de  = disp_de;
        pipe_d.hs  = disp_hs;
        pipe_d.vs  = disp_vs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    always_comb begin
        pix_out = BLACK;
        for (int k = 0; k < LANES; k++) begin
            if (pipe_q.sel[k]) pix_out = pix_out | bank_q[k];
        end
    end

    assign out_de = pipe_q.de;
    assign out_hs = pipe_q.hs;
    assign out_vs = pipe_q.vs;
endmodule

// File: rtl/qv_quad_checker.sv
`timescale 1ns/1ps
module qv_quad_checker #(
    parameter int DEPTH = 48,
    parameter int CW    = 6,
    parameter int AW    = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      wclk,
    input logic [3:0]      wvs,
    input logic [3:0]      whref,
    input logic [4*CW-1:0] wa_flat,
    input logic [3:0]      hit,
    input logic [AW-1:0]   rd_addr,
    input logic            disp_de,
    input logic            disp_hs,
    input logic            disp_vs,
    input logic [15:0]     pix_out,
    input logic            out_de,
    input logic            out_hs,
    input logic            out_vs
);
    logic live;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    for (genvar g = 0; g < 4; g++) begin : g_chk
        // R2: frame sync brings the write pointer back to zero
        p_restart_r2: assert property (@(posedge wclk[g]) disable iff (!rst_n)
            wvs[g] |=> (wa_flat[g*CW +: CW] == '0));
        // R3: idle edge leaves the pointer alone
        p_idle_hold_r3: assert property (@(posedge wclk[g]) disable iff (!rst_n)
            (!wvs[g] && !whref[g]) |=> $stable(wa_flat[g*CW +: CW]));
        // R4: pointer never runs past the bank size
        p_no_overflow_r4: assert property (@(posedge wclk[g]) disable iff (!rst_n)
            wa_flat[g*CW +: CW] <= CW'(DEPTH));
    end

    // R5: at most one region claims a coordinate
    p_one_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    // R10: read address stays inside the bank
    p_rd_in_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> (int'(rd_addr) < DEPTH));
    // R6: enable low gives black one clock later
    p_black_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !disp_de) |=> (pix_out == 16'h0000));
    // R7: delayed syncs follow inputs by exactly one clock
    p_sync_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (out_hs == $past(disp_hs) && out_vs == $past(disp_vs)
                  && out_de == $past(disp_de)));
endmodule

bind qv_quad_compositor qv_quad_checker #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wclk   (lane_clk),
    .wvs    (lane_vs),
    .whref  (lane_href),
    .wa_flat(wa_flat),
    .hit    (hit),
    .rd_addr(rd_addr),
    .disp_de(disp_de),
    .disp_hs(disp_hs),
    .disp_vs(disp_vs),
    .pix_out(pix_out),
    .out_de (out_de),
    .out_hs (out_hs),
    .out_vs (out_vs)
);

// File: tb/sim_qv_quad_compositor.sv
`timescale 1ns/1ps
module sim_qv_quad_compositor;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 8;
    localparam int H     = 6;
    localparam int DEPTH = W * H;
    localparam int FW    = 4 * W;
    localparam int FH    = 3 * H;
    localparam int XW    = $clog2(FW);
    localparam int YW    = $clog2(FH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mirror_en = 1'b0;
    logic pc0 = 1'b0, pc1 = 1'b0, pc2 = 1'b0, pc3 = 1'b0;
    logic cvs  [4];
    logic chref[4];
    logic [15:0] cd[4];
    logic [XW-1:0] dx = '0;
    logic [YW-1:0] dy = '0;
    logic dde = 1'b0, dhs = 1'b0, dvs = 1'b0;
    logic [15:0] pix_out;
    logic out_de, out_hs, out_vs;

    logic [15:0] model[4][DEPTH];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #7  pc0 = ~pc0;
    always #9  pc1 = ~pc1;
    always #11 pc2 = ~pc2;
    always #13 pc3 = ~pc3;

    qv_quad_compositor #(.IMG_W(W), .IMG_H(H)) u0 (
        .clk(clk), .rst_n(rst_n), .mirror_en(mirror_en),
        .cam_pclk({pc3, pc2, pc1, pc0}),
        .cam_vs({cvs[3], cvs[2], cvs[1], cvs[0]}),
        .cam_href({chref[3], chref[2], chref[1], chref[0]}),
        .cam_data({cd[3], cd[2], cd[1], cd[0]}),
        .disp_x(dx), .disp_y(dy), .disp_de(dde), .disp_hs(dhs), .disp_vs(dvs),
        .pix_out(pix_out), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_pos(input int k);
        case (k)
            0: @(posedge pc0);
            1: @(posedge pc1);
            2: @(posedge pc2);
            default: @(posedge pc3);
        endcase
    endtask

    task automatic wait_neg(input int k);
        case (k)
            0: @(negedge pc0);
            1: @(negedge pc1);
            2: @(negedge pc2);
            default: @(negedge pc3);
        endcase
    endtask

    // one frame on camera k; data is only valid around the rising edge (R1)
    task automatic cam_frame(input int k, input int n, input logic [15:0] base,
                             input bit gaps, input logic [3:0] tgt);
        wait_neg(k); cvs[k] = 1'b1;
        wait_neg(k); cvs[k] = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 0)) begin
                chref[k] = 1'b0; cd[k] = 16'hBAD0 ^ 16'(i);
                wait_neg(k);
            end
            chref[k] = 1'b1; cd[k] = base + 16'(i);
            wait_pos(k);
            #1 cd[k] = 16'hEEEE;
            wait_neg(k);
            if (i < DEPTH) begin
                for (int t = 0; t < 4; t++) if (tgt[t]) model[t][i] = base + 16'(i);
            end
        end
        chref[k] = 1'b0;
        wait_neg(k);
    endtask

    function automatic int region_of(input int x, input int y);
        int col = x / W;
        int band = y / H;
        if (band == 0 && col == 1) return 0;
        if (band == 1 && col == 0) return 1;
        if (band == 1 && col == 2) return 2;
        if (band == 2 && col == 1) return 3;
        return -1;
    endfunction

    // full scan plus two lines past the frame; checks one clock later (R7)
    task automatic scan(input string req, input logic de_val);
        int px = 0, py = 0;
        logic pde = 1'b0;
        bit have = 1'b0;
        for (int y = 0; y < FH + 2; y++) begin
            for (int x = 0; x < FW; x++) begin
                @(negedge clk);
                if (have) check_pix(req, px, py, pde);
                dx = XW'(x); dy = YW'(y); dde = de_val;
                dhs = (x == 0); dvs = (y == 0);
                px = x; py = y; pde = de_val; have = 1'b1;
            end
        end
        @(negedge clk);
        check_pix(req, px, py, pde);
        dde = 1'b0; dhs = 1'b0; dvs = 1'b0;
    endtask

    task automatic check_pix(input string req, input int x, input int y, input logic de);
        int r = region_of(x, y);
        logic [15:0] e = 16'h0000;
        if (de && r >= 0) e = model[r][(y % H) * W + (x % W)];
        chk((de && r >= 0) ? req : "R6", $sformatf("pix(%0d,%0d)", x, y), 32'(pix_out), 32'(e));
        chk("R7", $sformatf("sync(%0d,%0d)", x, y),
            {29'd0, out_de, out_hs, out_vs}, {29'd0, de, x == 0, y == 0});
    endtask

    task automatic t_reset();
        #1;
        chk("R9", "pix in reset", 32'(pix_out), 32'h0);
        chk("R9", "syncs in reset", {29'd0, out_de, out_hs, out_vs}, 32'h0);
    endtask

    task automatic t_all_cams();
        fork
            cam_frame(0, DEPTH, 16'h1000, 1'b0, 4'b0001);
            cam_frame(1, DEPTH, 16'h2000, 1'b0, 4'b0010);
            cam_frame(2, DEPTH, 16'h3000, 1'b0, 4'b0100);
            cam_frame(3, DEPTH, 16'h4000, 1'b0, 4'b1000);
        join
        scan("R1 R5 R10", 1'b1);
    endtask

    task automatic t_gaps_overflow();
        fork
            cam_frame(1, DEPTH, 16'h5100, 1'b1, 4'b0010);      // R3 idle gaps
            cam_frame(2, DEPTH + 5, 16'h6200, 1'b0, 4'b0100);  // R4 excess words
        join
        scan("R3 R4", 1'b1);
    endtask

    task automatic t_restart();
        cam_frame(3, 10, 16'h7000, 1'b0, 4'b1000);
        cam_frame(3, DEPTH, 16'h7800, 1'b0, 4'b1000);          // R2 fresh frame
        scan("R2", 1'b1);
    endtask

    task automatic t_mirror();
        mirror_en = 1'b1;
        #50;
        fork
            cam_frame(0, DEPTH, 16'h9000, 1'b0, 4'b1111);
            cam_frame(2, DEPTH, 16'hA000, 1'b0, 4'b0000);      // must be ignored
        join
        scan("R8", 1'b1);
        mirror_en = 1'b0;
        #50;
    endtask

    task automatic t_de_low();
        scan("R6", 1'b0);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            cvs[k] = 1'b0; chref[k] = 1'b0; cd[k] = 16'h0;
        end
        #(CLK_PERIOD * 3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD * 2);
        t_all_cams();
        t_gaps_overflow();
        t_restart();
        t_mirror();
        t_de_low();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule